// File: doc/BRIEF.md
# Two-Stage I2C Serial Clock Rate Generator

This block derives the I2C serial clock timing from the peripheral clock. The division is built from three cascaded pieces: a prescaler that divides by A+1, a second stage that divides the prescaler output by B+1, and a fixed phase counter of 22 units. The phase counter spends 11 units with the clock reference high and 11 units with it low. A and B are two fields of a 16-bit control word. The resulting serial clock rate is Fpclk / (22 x (A+1) x (B+1)).

Besides the free-running clock reference, the block emits a one-cycle timing strobe four times per serial clock period. In master mode, the bus engine uses these strobes to place its edges. In slave mode, the same strobes set the rate at which the bus is sampled, so the divisors must be chosen so that this rate is at least as fast as the fastest SCL expected on the bus.

The divisors are captured into internal registers in two situations: while the block is idle, and at the boundary where a new SCL period begins. A control word changed in mid-period therefore never shortens or stretches the pulse already in progress. After reset both divisors are zero, which gives the fastest rate.

Top module: `scl_rate_gen`

## Requirements
- R1: With A = ctl_word_i[15:14] and B = ctl_word_i[13:8], the time between consecutive rising edges of scl_ref_o is 22 x (A+1) x (B+1) clock cycles.
- R2: Within every period, scl_ref_o is high for exactly 11 x (A+1) x (B+1) cycles and then low for the same number of cycles.
- R3: ctl_word_i[7:0] has no effect on the period or on the high time.
- R4: During and right after reset, scl_ref_o is 1 and quarter_stb_o is 0, and the captured divisors are zero. A control word of zero therefore gives the 22-cycle period.
- R5: While enable_i is 0, scl_ref_o stays 1, quarter_stb_o stays 0 and all counters restart from zero.
- R6: A divisor change written while enabled is applied only from the next rising edge of scl_ref_o. The period already in progress completes with the old divisors.
- R7: quarter_stb_o pulses for exactly one cycle, four times per period. The pulses fall on phase units 0, 5, 11 and 16, so one pulse coincides with the cycle in which scl_ref_o rises and one with the cycle in which it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable_i | input | 1 | Run the divider; low holds it idle with SCL high |
| ctl_word_i | input | 16 | Control word; bits 15:14 select divisor A, bits 13:8 select divisor B |
| quarter_stb_o | output | 1 | One-cycle strobe at each quarter point of the SCL period |
| scl_ref_o | output | 1 | Free-running SCL reference |

## Verification
The embedded assertions check several properties on every cycle:
- the idle behaviour while the block is disabled;
- each stage counter staying within its captured limit;
- strobes being single-cycle and aligned with both SCL edges;
- the captured divisors changing only when idle or at a period boundary.

Period length, high time and the strobe count per period are products of all three stages, so only the bench's measured scenarios show them. These scenarios are:
- several (A, B) pairs, up to A=3 and B=63;
- a control word with its unused low byte set;
- a mid-period divisor change, whose effect must appear exactly one period late.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  localparam int CTL_W        = 16;
  localparam int DIVA_LSB     = 14;
  localparam int DIVA_W       = 2;
  localparam int DIVB_LSB     = 8;
  localparam int DIVB_W       = 6;
  localparam int HALF_UNITS   = 11;
  localparam int PERIOD_UNITS = 2 * HALF_UNITS;
  localparam int PH_W         = $clog2(PERIOD_UNITS);
  localparam int QTR_OFS      = HALF_UNITS / 2;
endpackage

// File: rtl/scl_div_stage.sv
module scl_div_stage #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         adv_i,
  input  logic [W-1:0] limit_i,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         at_limit;

  assign at_limit = (cnt_q == limit_i);
  assign wrap_o   = run_i && adv_i && at_limit;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i) begin
      cnt_d = '0;
    end else if (adv_i) begin
      cnt_d = at_limit ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R1
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= limit_i);

  // R5
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
  import scl_gen_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic unit_tick_i,
  output logic period_end_o,
  output logic scl_o,
  output logic qstb_o
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD_UNITS - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(HALF_UNITS);
  localparam logic [PH_W-1:0] PH_Q1   = PH_W'(QTR_OFS);
  localparam logic [PH_W-1:0] PH_Q3   = PH_W'(HALF_UNITS + QTR_OFS);

  logic [PH_W-1:0] ph_q, ph_d;
  logic            scl_q, scl_d;
  logic            stb_q, stb_d;

  assign period_end_o = run_i && unit_tick_i && (ph_q == PH_LAST);

  always_comb begin
    ph_d  = ph_q;
    scl_d = scl_q;
    stb_d = 1'b0;
    if (!run_i) begin
      ph_d  = '0;
      scl_d = 1'b1;
    end else if (unit_tick_i) begin
      ph_d  = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
      scl_d = (ph_d < PH_HALF);
      stb_d = (ph_d == '0) || (ph_d == PH_Q1) || (ph_d == PH_HALF) || (ph_d == PH_Q3);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '0;
      scl_q <= 1'b1;
      stb_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      scl_q <= scl_d;
      stb_q <= stb_d;
    end
  end

  assign scl_o  = scl_q;
  assign qstb_o = stb_q;

  // R5
  idle_scl_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (scl_o && !qstb_o));

  // R7
  stb_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qstb_o |=> !qstb_o);

  // R7
  stb_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_o) |-> qstb_o);

  // R7
  stb_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scl_o) |-> qstb_o);
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import scl_gen_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [CTL_W-1:0] ctl_word_i,
  output logic             quarter_stb_o,
  output logic             scl_ref_o
);
  logic [1:0]        rst_pipe_q;
  logic              rst_n_s;
  logic [DIVA_W-1:0] diva_q, diva_d;
  logic [DIVB_W-1:0] divb_q, divb_d;
  logic              cap_en;
  logic              wrap_a, unit_tick, period_end;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  // divisor capture: while idle, or where a new SCL period starts
  assign cap_en = !enable_i || period_end;

  always_comb begin
    diva_d = diva_q;
    divb_d = divb_q;
    if (cap_en) begin
      diva_d = ctl_word_i[DIVA_LSB +: DIVA_W];
      divb_d = ctl_word_i[DIVB_LSB +: DIVB_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      diva_q <= '0;
      divb_q <= '0;
    end else begin
      diva_q <= diva_d;
      divb_q <= divb_d;
    end
  end

  scl_div_stage #(.W(DIVA_W)) u_stage_a (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .run_i   (enable_i),
    .adv_i   (1'b1),
    .limit_i (diva_q),
    .wrap_o  (wrap_a)
  );

  scl_div_stage #(.W(DIVB_W)) u_stage_b (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .run_i   (enable_i),
    .adv_i   (wrap_a),
    .limit_i (divb_q),
    .wrap_o  (unit_tick)
  );

  scl_phase_gen u_phase (
    .clk_i        (clk_i),
    .rst_ni       (rst_n_s),
    .run_i        (enable_i),
    .unit_tick_i  (unit_tick),
    .period_end_o (period_end),
    .scl_o        (scl_ref_o),
    .qstb_o       (quarter_stb_o)
  );

  // R6
  div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (enable_i && !period_end) |=> ($stable(diva_q) && $stable(divb_q)));

  // R6
  rise_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    period_end |=> (scl_ref_o && quarter_stb_o));
endmodule

// File: tb/sim_scl_rate_gen.sv
module sim_scl_rate_gen;
  logic        clk, rst_n, en;
  logic [15:0] ctl;
  logic        stb, scl;

  int n_checks = 0;
  int n_fails  = 0;

  int    q_per[$];
  int    q_hi[$];
  string q_tag[$];

  scl_rate_gen u0 (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .enable_i      (en),
    .ctl_word_i    (ctl),
    .quarter_stb_o (stb),
    .scl_ref_o     (scl)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push_exp(input int a, input int b, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      q_per.push_back(22 * (a + 1) * (b + 1));
      q_hi.push_back(11 * (a + 1) * (b + 1));
      q_tag.push_back(tag);
    end
  endtask

  task automatic drive(input logic e, input logic [15:0] c);
    @(posedge clk);
    #2;
    en  = e;
    ctl = c;
  endtask

  // fresh start with divisors a, b and a chosen low byte
  task automatic run_cfg(input int a, input int b, input logic [7:0] lo,
                         input int n, input string tag);
    drive(1'b0, ctl);
    drive(1'b0, {a[1:0], b[5:0], lo});
    push_exp(a, b, n, tag);
    drive(1'b1, {a[1:0], b[5:0], lo});
    wait (q_per.size() == 0);
  endtask

  // monitor: measures periods, high times and strobes; pops the scoreboard
  int cyc = 0, rise_cyc = 0, fall_cyc = 0, stb_cnt = 0;
  bit have_rise = 0, scl_prev = 1;
  always @(negedge clk) begin
    cyc++;
    if (!en || !rst_n) begin
      have_rise = 0;
      stb_cnt   = 0;
    end else begin
      if (scl && !scl_prev) begin
        check(stb == 1'b1, "R7 strobe at rise", stb, 1);
        if (have_rise) begin
          if (q_per.size() == 0) begin
            check(1'b0, "R1 unexpected period", cyc - rise_cyc, 0);
          end else begin
            int    ep, eh;
            string tg;
            ep = q_per.pop_front();
            eh = q_hi.pop_front();
            tg = q_tag.pop_front();
            check(cyc - rise_cyc == ep, {tg, " period"}, cyc - rise_cyc, ep);
            check(fall_cyc - rise_cyc == eh, {"R2 high time ", tg}, fall_cyc - rise_cyc, eh);
            check(stb_cnt == 4, "R7 strobes per period", stb_cnt, 4);
          end
        end
        have_rise = 1;
        rise_cyc  = cyc;
        stb_cnt   = 1;
      end else begin
        if (stb) stb_cnt++;
        if (!scl && scl_prev) begin
          check(stb == 1'b1, "R7 strobe at fall", stb, 1);
          fall_cyc = cyc;
        end
      end
    end
    scl_prev = scl;
  end

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("  %0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    en    = 1'b0;
    ctl   = 16'h0000;
    repeat (4) @(negedge clk);
    // R4 reset state
    check(scl == 1'b1, "R4 scl in reset", scl, 1);
    check(stb == 1'b0, "R4 strobe in reset", stb, 0);
    @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(scl == 1'b1, "R4 scl after reset", scl, 1);
    check(stb == 1'b0, "R4 strobe after reset", stb, 0);

    // R4 zero control word gives the fastest rate
    run_cfg(0, 0, 8'h00, 3, "R4 R1 a0b0");

    // R5 idle hold: no strobes, SCL high
    drive(1'b0, 16'hFFFF);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      check(scl == 1'b1 && stb == 1'b0, "R5 idle hold", {scl, stb}, 2);
    end

    run_cfg(1, 0, 8'h00, 3, "R1 a1b0");
    run_cfg(0, 1, 8'h00, 3, "R1 a0b1");
    run_cfg(3, 0, 8'h00, 2, "R1 a3b0");
    run_cfg(2, 5, 8'h00, 3, "R1 a2b5");
    run_cfg(0, 63, 8'h00, 2, "R1 a0b63");
    run_cfg(3, 63, 8'h00, 3, "R1 a3b63");

    // R3 low byte ignored
    run_cfg(1, 2, 8'hFF, 2, "R3 lowbyte ff");
    run_cfg(1, 2, 8'h5A, 2, "R3 lowbyte 5a");

    // R6 mid-period change: current period keeps old divisors
    repeat (10) @(negedge clk);
    push_exp(1, 2, 1, "R6 old period");
    push_exp(0, 3, 2, "R6 new period");
    drive(1'b1, {2'd0, 6'd3, 8'h00});
    wait (q_per.size() == 0);
    drive(1'b0, ctl);
    repeat (5) @(negedge clk);

    $display("  %0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule